// File: doc/BRIEF.md
# Single-Inductor Pseudo-Continuous Switch Sequencer

This block drives the gates of a single-inductor boost stage that serves several outputs in turn. A switching cycle is split into consecutive phases, one for each output, in ascending output order. Each phase first charges the inductor through the main switch. It then discharges the inductor into its own output. When the current has fallen to the freewheel level, the inductor is shorted through the freewheel switch until the phase ends. Break-before-make gaps surround the freewheel interval, so energy left over from one output never leaks into the next.

A controller sets the per-output phase and charge lengths in clock ticks and pulses `cycle_start` to begin a cycle. An analog comparator raises `at_idc` once the inductor current is down to the freewheel level. If an output's phase ends while it is still discharging, the block records that continuous conduction was entered on that output.

Top module: `pccm_switch_seq`

## Requirements
- R1: A `cycle_start` high at a rising edge while the block is idle starts a cycle on the next tick. Phase 0 runs first, then 1, up to N_OUT-1, and the block then returns to idle with every gate off. A `cycle_start` seen while a cycle is running is ignored.
- R2: Phase i lasts exactly the number of ticks in field i of `phase_len`, where field i is bits [i*CNT_W +: CNT_W]. A field of 0 selects CYCLE_TICKS/N_OUT ticks.
- R3: For the first `charge_len` field i ticks of phase i, only `gate_main` is on. After that, only `gate_out[i]` is on. `at_idc` has no effect while charging.
- R4: If `at_idc` is high at a rising edge during a discharge tick, the following DEAD_TICKS ticks have every gate off. Then `gate_fw` turns on.
- R5: `gate_fw` is off for the last DEAD_TICKS ticks of every phase, and all gates are off in those ticks. If the flag arrives when no freewheel tick remains before that window, the block goes straight from discharge to all-off.
- R6: If a phase ends while still discharging, bit i of `ccm_flag` sets on the next tick and stays set until reset. The next phase still begins with `gate_main` at once.
- R7: Phase and charge lengths are captured only when a cycle starts. Changes on those inputs during a cycle do not affect it.
- R8: During and after reset, all gates and `ccm_flag` are 0. At most one of `gate_main`, `gate_out`, `gate_fw` is ever on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Starts a switching cycle when idle |
| phase_len | input | N_OUT*CNT_W | Per-output phase length in ticks, 0 for default |
| charge_len | input | N_OUT*CNT_W | Per-output charge length in ticks |
| at_idc | input | 1 | Inductor current has reached the freewheel level |
| gate_main | output | 1 | Main (charging) switch enable |
| gate_out | output | N_OUT | Per-output discharge switch enables |
| gate_fw | output | 1 | Freewheel switch enable |
| ccm_flag | output | N_OUT | Sticky per-output continuous-conduction marker |

## Verification
Every internal state of the block decodes straight onto the gate pins in the same tick. A wrong phase index, tick count or dead-time count therefore shows as a wrong gate pattern within one clock of the error, and at the latest at the next phase boundary. A missed phase end or a wrong latch of the lengths moves every later edge of the cycle. A mistake in the conduction marker shows on `ccm_flag` on the first tick of the following phase. The bench compares the full gate and flag vector on every tick against a timeline it derives from the programmed lengths and the tick at which the flag is raised.

// File: rtl/pccm_switch_seq.sv
module pccm_switch_seq #(
  parameter int N_OUT       = 2,
  parameter int CNT_W       = 8,
  parameter int DEAD_TICKS  = 2,
  parameter int CYCLE_TICKS = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cycle_start,
  input  logic [N_OUT*CNT_W-1:0] phase_len,
  input  logic [N_OUT*CNT_W-1:0] charge_len,
  input  logic                   at_idc,
  output logic                   gate_main,
  output logic [N_OUT-1:0]       gate_out,
  output logic                   gate_fw,
  output logic [N_OUT-1:0]       ccm_flag
);
  localparam int IDX_W = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int DW    = $clog2(DEAD_TICKS + 1);
  localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(CYCLE_TICKS / N_OUT);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(N_OUT - 1);

  typedef enum logic [2:0] {S_IDLE, S_CHG, S_DIS, S_DIN, S_FW, S_DOUT} st_t;

  st_t                    st;
  logic [IDX_W-1:0]       idx;
  logic [CNT_W-1:0]       tick;
  logic [DW-1:0]          dcnt;
  logic [N_OUT*CNT_W-1:0] plen_q, clen_q, plen_eff;
  logic [CNT_W-1:0]       cur_plen, cur_clen, fw_end;
  logic                   phase_end, chg_done, past_fw;

  for (genvar i = 0; i < N_OUT; i++) begin : g_len
    assign plen_eff[i*CNT_W +: CNT_W] =
      (phase_len[i*CNT_W +: CNT_W] == '0) ? DEF_LEN : phase_len[i*CNT_W +: CNT_W];
    assign gate_out[i] = (st == S_DIS) && (idx == IDX_W'(i));
  end

  assign cur_plen  = plen_q[idx*CNT_W +: CNT_W];
  assign cur_clen  = clen_q[idx*CNT_W +: CNT_W];
  assign fw_end    = cur_plen - CNT_W'(DEAD_TICKS + 1);
  assign phase_end = (tick == cur_plen - CNT_W'(1));
  assign chg_done  = ({1'b0, tick} + (CNT_W+1)'(1)) >= {1'b0, cur_clen};
  assign past_fw   = (tick >= fw_end);

  assign gate_main = (st == S_CHG);
  assign gate_fw   = (st == S_FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      tick     <= '0;
      dcnt     <= '0;
      plen_q   <= '0;
      clen_q   <= '0;
      ccm_flag <= '0;
    end else if (st == S_IDLE) begin
      if (cycle_start) begin
        plen_q <= plen_eff;
        clen_q <= charge_len;
        idx    <= '0;
        tick   <= '0;
        st     <= S_CHG;
      end
    end else if (phase_end) begin
      if (st == S_DIS) ccm_flag[idx] <= 1'b1;
      tick <= '0;
      if (idx == LAST) begin
        st <= S_IDLE;
      end else begin
        idx <= idx + 1'b1;
        st  <= S_CHG;
      end
    end else begin
      tick <= tick + 1'b1;
      case (st)
        S_CHG: if (chg_done) st <= S_DIS;
        S_DIS: if (at_idc) begin
          dcnt <= '0;
          st   <= past_fw ? S_DOUT : S_DIN;
        end
        S_DIN: begin
          if (past_fw) st <= S_DOUT;
          else if (dcnt == DW'(DEAD_TICKS - 1)) st <= S_FW;
          else dcnt <= dcnt + 1'b1;
        end
        S_FW: if (past_fw) st <= S_DOUT;
        default: ;
      endcase
    end
  end

  logic [N_OUT+1:0] gv;
  assign gv = {gate_main, gate_out, gate_fw};

  AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gv)); // R8
  AST_DEAD_BEFORE_FW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fw) |-> $past(gv) == '0); // R4
  AST_DEAD_AFTER_FW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_fw) |-> gv == '0); // R5
  AST_DIS_AFTER_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gate_out) |-> $past(gate_main)); // R3

  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    AST_CCM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ccm_flag[i] |=> ccm_flag[i]); // R6
  end
endmodule

// File: tb/pccm_switch_seq_tb_top.sv
`timescale 1ns/1ps
module pccm_switch_seq_tb_top;
  localparam int N = 2, W = 8, D = 2, CYC = 40;

  logic clk = 0, rst_n = 0, cycle_start = 0, at_idc = 0;
  logic [N*W-1:0] phase_len = '0, charge_len = '0;
  logic gate_main, gate_fw;
  logic [N-1:0] gate_out, ccm_flag;

  pccm_switch_seq #(.N_OUT(N), .CNT_W(W), .DEAD_TICKS(D), .CYCLE_TICKS(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .phase_len(phase_len),
    .charge_len(charge_len), .at_idc(at_idc), .gate_main(gate_main),
    .gate_out(gate_out), .gate_fw(gate_fw), .ccm_flag(ccm_flag));

  always #2 clk = ~clk;

  typedef struct { logic [5:0] v; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;
  int Praw[N], P[N], C[N], F[N];
  logic [1:0] ccm_exp = '0;

  task automatic push(input logic [3:0] g, input string tag);
    item_t it;
    it.v = {g, ccm_exp};
    it.tag = tag;
    q.push_back(it);
  endtask

  // Expected gates {main, out1, out0, fw} for phase i, tick t.
  function automatic logic [3:0] expg(input int i, input int t, output string cat);
    int ts, fwe;
    logic [3:0] ob;
    ob = (i == 0) ? 4'b0010 : 4'b0100;
    ts = (C[i] > F[i]) ? C[i] : F[i];
    fwe = P[i] - 1 - D;
    if (t < C[i]) begin cat = "R3 charge"; return 4'b1000; end
    if (ts >= P[i] - 1 || t <= ts) begin cat = "R3 discharge"; return ob; end
    if (t >= ts + D + 1 && t <= fwe) begin cat = "R4 freewheel"; return 4'b0001; end
    cat = "R5 dead"; return 4'b0000;
  endfunction

  task automatic run_cyc(input string tag, input bit poke, input bit scramble);
    string cat;
    for (int i = 0; i < N; i++) begin
      phase_len[i*W +: W]  = W'(Praw[i]);
      charge_len[i*W +: W] = W'(C[i]);
      P[i] = (Praw[i] == 0) ? CYC / N : Praw[i];
    end
    at_idc = 0;
    cycle_start = 1;
    @(negedge clk);
    cycle_start = 0;
    if (scramble) begin phase_len = {W'(3), W'(3)}; charge_len = {W'(1), W'(1)}; end // R7
    for (int i = 0; i < N; i++) begin
      for (int t = 0; t < P[i]; t++) begin
        logic [3:0] g;
        g = expg(i, t, cat);
        push(g, {tag, " ", cat});
        at_idc = (t >= F[i]);
        cycle_start = poke && i == 0 && t == 3; // R1 start while busy
        @(negedge clk);
      end
      if (((C[i] > F[i]) ? C[i] : F[i]) >= P[i] - 1) ccm_exp[i] = 1'b1; // R6
    end
    cycle_start = 0;
    at_idc = 0;
    push(4'b0000, {tag, " R1 idle after cycle"});
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : monitor
    item_t it;
    logic [5:0] act;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        act = {gate_main, gate_out[1], gate_out[0], gate_fw, ccm_flag};
        checks++;
        if (act !== it.v) begin
          fails++;
          $display("FAIL %s: actual %b expected %b", it.tag, act, it.v);
        end
      end
    end
  end

  initial begin : driver
    repeat (2) @(negedge clk);
    push(4'b0000, "R8 reset state");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    push(4'b0000, "R8 idle after reset");
    @(negedge clk);
    Praw = '{20, 20}; C = '{5, 6}; F = '{9, 10};
    run_cyc("balanced", 0, 0);
    Praw = '{14, 26}; C = '{4, 8}; F = '{6, 20};
    run_cyc("R7 unbalanced latched", 1, 1);
    Praw = '{16, 16}; C = '{6, 3}; F = '{0, 0};
    run_cyc("R3 flag during charge", 0, 0);
    Praw = '{16, 18}; C = '{4, 4}; F = '{13, 15};
    run_cyc("R5 late flag", 0, 0);
    Praw = '{0, 0}; C = '{5, 5}; F = '{8, 12};
    run_cyc("R2 default length", 0, 0);
    Praw = '{12, 12}; C = '{3, 3}; F = '{5, 99};
    run_cyc("R6 ccm out1", 0, 0);
    Praw = '{12, 12}; C = '{3, 3}; F = '{99, 5};
    run_cyc("R6 ccm out0 sticky", 0, 0);
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule